// File: doc/BRIEF.md
# Floating Result Normalizer with Rounding and Exponent Range Check

This block finishes a floating-point result once the arithmetic is done. It takes a 35-bit primary fraction, a 35-bit extension fraction that holds the bits below it, an 18-bit two's complement exponent and a sign. It shifts the 70-bit primary:extension pair left until the primary's leading bit is set, subtracting one from the exponent for each shift. It turns an all-zero pair into a clean zero. It can round the primary using the extension's top bit, and it then reports whether the final exponent still fits in 18 bits.

A client places the operands and three control bits on the inputs and pulses `start`. The unit performs one shift per clock, with a bound of 70 shifts. It then presents the adjusted primary fraction, the extension, exponent, sign, a guard flag and a 3-bit status code, qualified by a one-cycle `done` pulse. The status codes are odd numbers. Subtracting one from a code gives the word offset of that condition in an exception vector table kept by the client. The code values for a divide error and a memory error are reserved for other units and are never produced here.

Top module: `nrr_unit`

## Requirements
- R1: A `start` seen while idle captures all inputs. `done` pulses high for exactly one cycle, s+2 clock edges after the capturing edge, where s is the number of shifts performed. s is 0 when normalization is disabled or the pair is zero. The outputs change only on the edge that raises `done`.
- R2: With `no_norm`=0 and a nonzero pair, {frac, ext} (70 bits, frac in the upper half) is shifted left one bit per shift until frac bit 34 is 1. Ext bit 34 moves into frac bit 0, a zero enters ext bit 0, and the exponent falls by one per shift.
- R3: With `no_norm`=0 and both fractions zero, the sign and the exponent are forced to 0 and status is 0.
- R4: With `no_norm`=1, no shift occurs: fraction, extension, sign and exponent pass through, changed only by rounding.
- R5: `guard` is 1 exactly when `round_req`=1 and ext bit 34 (after normalization) is 1. In every other case it is 0.
- R6: When `guard` is 1 and `no_round`=0, frac is incremented by one. When `no_round`=1, frac is not incremented, though `guard` is still set.
- R7: If the increment carries out of bit 34 (frac was all ones), frac becomes only bit 34 set and the exponent rises by one.
- R8: Status is 1 (overflow) if the final exponent exceeds +131071, 3 (underflow) if it is below −131072, and 0 otherwise. Codes 5 and 7 are never produced. `exp_out` carries the low 18 bits of the final exponent in two's complement.
- R9: A `start` pulse while a result is in progress is ignored: the pending result follows the first operands and its timing.
- R10: After reset, `done`, `guard`, `sign_out`, `frac_out`, `ext_out`, `exp_out` and `status` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin processing the presented operands |
| no_norm | input | 1 | 1 skips normalization and zero detection |
| no_round | input | 1 | 1 blocks the rounding increment |
| round_req | input | 1 | 1 allows rounding from the extension's top bit |
| frac_in | input | 35 | Primary fraction magnitude |
| ext_in | input | 35 | Extension fraction below the primary |
| exp_in | input | 18 | Exponent, two's complement |
| sign_in | input | 1 | Sign of the value |
| done | output | 1 | One-cycle result-valid pulse |
| frac_out | output | 35 | Adjusted primary fraction |
| ext_out | output | 35 | Extension after shifting |
| exp_out | output | 18 | Low 18 bits of the final exponent |
| sign_out | output | 1 | Resulting sign |
| guard | output | 1 | Rounding condition seen |
| status | output | 3 | 0 ok, 1 overflow, 3 underflow |

## Verification
Every result is due s+2 edges after the edge that captures `start`, where s is the shift count. The bench model derives s from the operands and the requirements, not from the design. The bench drives `start` on a falling edge and counts falling edges until `done` is seen. It checks that count against s+2 and samples all outputs at that same falling edge, clear of the rising edge that updated them. A second `start` injected two cycles into a long normalization must not change that timing or the result.

// File: rtl/nrr_pkg.sv
package nrr_pkg;
  // Result codes; code minus one is the offset into the client's exception table
  typedef enum logic [2:0] {
    ST_OK     = 3'd0,
    ST_OVF    = 3'd1,
    ST_UNF    = 3'd3,
    ST_DIVERR = 3'd5,
    ST_MEMERR = 3'd7
  } nrr_status_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SHIFT  = 2'd1,
    PH_FINISH = 2'd2
  } nrr_phase_e;
endpackage

// File: rtl/nrr_shift_step.sv
module nrr_shift_step #(
  parameter int FRAC_W = 35
) (
  input  logic [FRAC_W-1:0] frac_i,
  input  logic [FRAC_W-1:0] ext_i,
  output logic [FRAC_W-1:0] frac_o,
  output logic [FRAC_W-1:0] ext_o,
  output logic              lead_o,
  output logic              zero_o
);
  // One-bit left shift of the joined pair; extension MSB enters the primary LSB
  assign {frac_o, ext_o} = {frac_i[FRAC_W-2:0], ext_i, 1'b0};
  assign lead_o          = frac_i[FRAC_W-1];
  assign zero_o          = ~|{frac_i, ext_i};
endmodule

// File: rtl/nrr_round_range.sv
module nrr_round_range
  import nrr_pkg::*;
#(
  parameter int FRAC_W = 35,
  parameter int EXP_W  = 18,
  parameter int EW     = 26
) (
  input  logic [FRAC_W-1:0]    frac_i,
  input  logic signed [EW-1:0] exp_i,
  input  logic                 ext_lead_i,
  input  logic                 round_req_i,
  input  logic                 no_round_i,
  output logic [FRAC_W-1:0]    frac_o,
  output logic signed [EW-1:0] exp_o,
  output logic                 guard_o,
  output logic [2:0]           status_o
);
  localparam logic signed [EW-1:0] EMAX = {{(EW-EXP_W+1){1'b0}}, {(EXP_W-1){1'b1}}};
  localparam logic signed [EW-1:0] EMIN = {{(EW-EXP_W+1){1'b1}}, {(EXP_W-1){1'b0}}};
  localparam logic signed [EW-1:0] ONE  = {{(EW-1){1'b0}}, 1'b1};
  localparam logic [FRAC_W-1:0]    TOP  = {1'b1, {(FRAC_W-1){1'b0}}};

  logic              rnd_hit;
  logic              bump;
  logic [FRAC_W:0]   sum;
  logic signed [EW-1:0] e_fin;

  always_comb begin
    rnd_hit = round_req_i & ext_lead_i;
    bump    = rnd_hit & ~no_round_i;
    sum     = {1'b0, frac_i} + {{FRAC_W{1'b0}}, bump};
    if (sum[FRAC_W]) begin
      frac_o = TOP;
      e_fin  = exp_i + ONE;
    end else begin
      frac_o = sum[FRAC_W-1:0];
      e_fin  = exp_i;
    end
    exp_o   = e_fin;
    guard_o = rnd_hit;
    if (e_fin > EMAX)      status_o = ST_OVF;
    else if (e_fin < EMIN) status_o = ST_UNF;
    else                   status_o = ST_OK;
  end
endmodule

// File: rtl/nrr_unit.sv
module nrr_unit
  import nrr_pkg::*;
#(
  parameter int FRAC_W = 35,
  parameter int EXP_W  = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              no_norm,
  input  logic              no_round,
  input  logic              round_req,
  input  logic [FRAC_W-1:0] frac_in,
  input  logic [FRAC_W-1:0] ext_in,
  input  logic [EXP_W-1:0]  exp_in,
  input  logic              sign_in,
  output logic              done,
  output logic [FRAC_W-1:0] frac_out,
  output logic [FRAC_W-1:0] ext_out,
  output logic [EXP_W-1:0]  exp_out,
  output logic              sign_out,
  output logic              guard,
  output logic [2:0]        status
);
  localparam int LIMIT = 2 * FRAC_W;
  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam int EW    = EXP_W + CNT_W + 1;
  localparam logic signed [EW-1:0] ONE = {{(EW-1){1'b0}}, 1'b1};

  nrr_phase_e           phase;
  logic [FRAC_W-1:0]    work_frac, work_ext;
  logic signed [EW-1:0] work_exp;
  logic                 work_sign;
  logic [CNT_W-1:0]     step_cnt;
  logic                 cfg_nonorm, cfg_noround, cfg_rndreq;

  logic [FRAC_W-1:0]    sh_frac, sh_ext;
  logic                 sh_lead, sh_zero;
  logic [FRAC_W-1:0]    rr_frac;
  logic signed [EW-1:0] rr_exp;
  logic                 rr_guard;
  logic [2:0]           rr_status;

  nrr_shift_step #(.FRAC_W(FRAC_W)) u_step (
    .frac_i (work_frac),
    .ext_i  (work_ext),
    .frac_o (sh_frac),
    .ext_o  (sh_ext),
    .lead_o (sh_lead),
    .zero_o (sh_zero)
  );

  nrr_round_range #(.FRAC_W(FRAC_W), .EXP_W(EXP_W), .EW(EW)) u_rr (
    .frac_i      (work_frac),
    .exp_i       (work_exp),
    .ext_lead_i  (work_ext[FRAC_W-1]),
    .round_req_i (cfg_rndreq),
    .no_round_i  (cfg_noround),
    .frac_o      (rr_frac),
    .exp_o       (rr_exp),
    .guard_o     (rr_guard),
    .status_o    (rr_status)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase       <= PH_IDLE;
      work_frac   <= '0;
      work_ext    <= '0;
      work_exp    <= '0;
      work_sign   <= 1'b0;
      step_cnt    <= '0;
      cfg_nonorm  <= 1'b0;
      cfg_noround <= 1'b0;
      cfg_rndreq  <= 1'b0;
      done        <= 1'b0;
      frac_out    <= '0;
      ext_out     <= '0;
      exp_out     <= '0;
      sign_out    <= 1'b0;
      guard       <= 1'b0;
      status      <= ST_OK;
    end else begin
      done <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (start) begin
            work_frac   <= frac_in;
            work_ext    <= ext_in;
            work_exp    <= {{(EW-EXP_W){exp_in[EXP_W-1]}}, exp_in};
            work_sign   <= sign_in;
            cfg_nonorm  <= no_norm;
            cfg_noround <= no_round;
            cfg_rndreq  <= round_req;
            step_cnt    <= '0;
            phase       <= PH_SHIFT;
          end
        end
        PH_SHIFT: begin
          if (cfg_nonorm) begin
            phase <= PH_FINISH;
          end else if (sh_zero) begin
            work_sign <= 1'b0;
            work_exp  <= '0;
            phase     <= PH_FINISH;
          end else if (sh_lead || step_cnt == CNT_W'(LIMIT)) begin
            phase <= PH_FINISH;
          end else begin
            work_frac <= sh_frac;
            work_ext  <= sh_ext;
            work_exp  <= work_exp - ONE;
            step_cnt  <= step_cnt + CNT_W'(1);
          end
        end
        PH_FINISH: begin
          frac_out <= rr_frac;
          ext_out  <= work_ext;
          exp_out  <= rr_exp[EXP_W-1:0];
          sign_out <= work_sign;
          guard    <= rr_guard;
          status   <= rr_status;
          done     <= 1'b1;
          phase    <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nrr_checker.sv
module nrr_checker
  import nrr_pkg::*;
#(
  parameter int FRAC_W = 35,
  parameter int EXP_W  = 18,
  parameter int EW     = 26,
  parameter int CNT_W  = 7
) (
  input logic                 clk,
  input logic                 rst,
  input nrr_phase_e           phase,
  input logic                 cfg_nonorm,
  input logic                 cfg_rndreq,
  input logic [CNT_W-1:0]     step_cnt,
  input logic [FRAC_W-1:0]    work_frac,
  input logic [FRAC_W-1:0]    work_ext,
  input logic signed [EW-1:0] work_exp,
  input logic                 done,
  input logic [FRAC_W-1:0]    frac_out,
  input logic [FRAC_W-1:0]    ext_out,
  input logic [EXP_W-1:0]     exp_out,
  input logic                 sign_out,
  input logic                 guard,
  input logic [2:0]           status
);
  localparam int LIMIT = 2 * FRAC_W;

  logic shifting;
  assign shifting = (phase == PH_SHIFT) && !cfg_nonorm && !work_frac[FRAC_W-1]
                    && (|{work_frac, work_ext}) && (step_cnt != CNT_W'(LIMIT));

  // R1: done is a single-cycle pulse
  a_r1_done_pulse: assert property (@(posedge clk) disable iff (rst) done |=> !done);

  // R1: results move only together with done
  a_r1_frac_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(frac_out) |-> done);

  // R2: each shift lowers the exponent by one
  a_r2_exp_step: assert property (@(posedge clk) disable iff (rst)
    shifting |=> (work_exp == $past(work_exp) - EW'(1)));

  // R2: extension MSB feeds the primary LSB
  a_r2_feed: assert property (@(posedge clk) disable iff (rst)
    shifting |=> (work_frac[0] == $past(work_ext[FRAC_W-1])));

  // R2, R7: normalized nonzero results have the leading bit set
  a_r2_leading_set: assert property (@(posedge clk) disable iff (rst)
    (done && !cfg_nonorm && (|{frac_out, ext_out})) |-> frac_out[FRAC_W-1]);

  // R3: true zero clears sign and exponent
  a_r3_true_zero: assert property (@(posedge clk) disable iff (rst)
    (done && !cfg_nonorm && !(|{frac_out, ext_out})) |-> (!sign_out && exp_out == '0 && status == 3'd0));

  // R5: no guard without a round request
  a_r5_no_guard: assert property (@(posedge clk) disable iff (rst)
    (done && !cfg_rndreq) |-> !guard);

  // R8: only the three codes this unit owns appear
  a_r8_status_codes: assert property (@(posedge clk) disable iff (rst)
    done |-> (status == 3'd0 || status == 3'd1 || status == 3'd3));

  // R8: status changes only with done
  a_r8_status_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(status) |-> done);
endmodule

bind nrr_unit nrr_checker #(
  .FRAC_W(FRAC_W), .EXP_W(EXP_W), .EW(EW), .CNT_W(CNT_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .phase      (phase),
  .cfg_nonorm (cfg_nonorm),
  .cfg_rndreq (cfg_rndreq),
  .step_cnt   (step_cnt),
  .work_frac  (work_frac),
  .work_ext   (work_ext),
  .work_exp   (work_exp),
  .done       (done),
  .frac_out   (frac_out),
  .ext_out    (ext_out),
  .exp_out    (exp_out),
  .sign_out   (sign_out),
  .guard      (guard),
  .status     (status)
);

// File: tb/nrr_unit_test.sv
`timescale 1ns/1ps
module nrr_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        no_norm = 1'b0, no_round = 1'b0, round_req = 1'b0;
  logic [34:0] frac_in = '0, ext_in = '0;
  logic [17:0] exp_in = '0;
  logic        sign_in = 1'b0;
  logic        done;
  logic [34:0] frac_out, ext_out;
  logic [17:0] exp_out;
  logic        sign_out, guard;
  logic [2:0]  status;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  nrr_unit uut (
    .clk(clk), .rst(rst), .start(start), .no_norm(no_norm), .no_round(no_round),
    .round_req(round_req), .frac_in(frac_in), .ext_in(ext_in), .exp_in(exp_in),
    .sign_in(sign_in), .done(done), .frac_out(frac_out), .ext_out(ext_out),
    .exp_out(exp_out), .sign_out(sign_out), .guard(guard), .status(status)
  );

  task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Expected result computed from the requirements
  task automatic model(input logic [34:0] f, input logic [34:0] x, input logic [17:0] ei,
                       input logic s, input logic nn, input logic nr, input logic rq,
                       output logic [34:0] fo, output logic [34:0] xo, output logic [17:0] eo,
                       output logic so, output logic go, output logic [2:0] sto, output int lat);
    logic [69:0] p;
    int e;
    int sh;
    p  = {f, x};
    e  = $signed(ei);
    sh = 0;
    so = s;
    if (!nn) begin
      if (p == '0) begin
        so = 1'b0;
        e  = 0;
      end else begin
        while (!p[69]) begin
          p = p << 1;
          e--;
          sh++;
        end
      end
    end
    fo = p[69:35];
    xo = p[34:0];
    go = rq && xo[34];
    if (go && !nr) begin
      if (fo == {35{1'b1}}) begin
        fo = 35'h1 << 34;
        e++;
      end else begin
        fo = fo + 35'd1;
      end
    end
    if (e > 131071)       sto = 3'd1;
    else if (e < -131072) sto = 3'd3;
    else                  sto = 3'd0;
    eo  = 18'(e);
    lat = sh + 2;
  endtask

  task automatic one(input string tag, input logic [34:0] f, input logic [34:0] x,
                     input logic [17:0] ei, input logic s, input logic nn,
                     input logic nr, input logic rq, input bit poke);
    logic [34:0] fo, xo;
    logic [17:0] eo;
    logic so, go;
    logic [2:0] sto;
    int lat;
    int n;
    model(f, x, ei, s, nn, nr, rq, fo, xo, eo, so, go, sto, lat);
    @(negedge clk);
    frac_in = f; ext_in = x; exp_in = ei; sign_in = s;
    no_norm = nn; no_round = nr; round_req = rq;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 200) begin
      @(negedge clk);
      n++;
      if (poke && n == 2) begin
        frac_in = 35'h7; ext_in = '0; exp_in = 18'h00010; sign_in = ~s;
        no_norm = 1'b1; round_req = 1'b1; no_round = 1'b0;
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    check(poke ? "R9" : "R1", "latency", 64'(n), 64'(lat));
    check(tag, "frac", 64'(frac_out), 64'(fo));
    check(tag, "ext", 64'(ext_out), 64'(xo));
    check(tag, "exp", 64'(exp_out), 64'(eo));
    check(tag, "sign", 64'(sign_out), 64'(so));
    check(tag, "guard", 64'(guard), 64'(go));
    check(tag, "status", 64'(status), 64'(sto));
    @(negedge clk);
    check("R1", "done_low_after", 64'(done), 64'd0);
  endtask

  initial begin
    logic [34:0] f, x;
    logic [17:0] e;
    int unused_seed;
    unused_seed = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    check("R10", "done", 64'(done), 64'd0);
    check("R10", "frac", 64'(frac_out), 64'd0);
    check("R10", "ext", 64'(ext_out), 64'd0);
    check("R10", "exp", 64'(exp_out), 64'd0);
    check("R10", "sign", 64'(sign_out), 64'd0);
    check("R10", "guard", 64'(guard), 64'd0);
    check("R10", "status", 64'(status), 64'd0);

    // R3: true zero clears sign and exponent
    one("R3", '0, '0, 18'd1234, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    // R4: bypass keeps zero's sign and exponent, and a small fraction unshifted
    one("R4", '0, '0, 18'd1234, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    one("R4", 35'h5, 35'h3, 18'h3FFF0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    // R2: all bits in the extension, longest normalization (69 shifts)
    one("R2", '0, 35'h1, 18'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    // R7: round carry-out
    one("R7", {35{1'b1}}, 35'h1 << 34, 18'd5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    // R6: rounding inhibited, guard still set
    one("R6", {35{1'b1}}, 35'h1 << 34, 18'd5, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    one("R6", 35'h1 << 34, 35'h1 << 34, 18'd7, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    // R5: no round request means no guard
    one("R5", 35'h1 << 34, {35{1'b1}}, 18'd9, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    // R8: overflow via round carry at the top exponent
    one("R8", {35{1'b1}}, 35'h1 << 34, 18'h1FFFF, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    // R8: underflow via one shift at the bottom exponent
    one("R8", 35'h1 << 33, '0, 18'h20000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    // R9: second start mid-normalization is ignored
    one("R9", 35'h1, 35'h0, 18'd100, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);

    // R2: random patterns with varied leading-zero counts
    for (int i = 0; i < 400; i++) begin
      f = 35'({$urandom, $urandom}) >> ($urandom % 40);
      x = 35'({$urandom, $urandom}) >> ($urandom % 40);
      case ($urandom % 4)
        0: e = 18'h1FFFF - 18'($urandom % 4);
        1: e = 18'h20000 + 18'($urandom % 80);
        default: e = 18'($urandom);
      endcase
      one("R2", f, x, e, 1'($urandom), 1'(($urandom % 5) == 0),
          1'($urandom), 1'($urandom), 1'b0);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      finished = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual expired expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule